// File: doc/BRIEF.md
# Inbound DMA Address Translator

This block sits on the inbound path of an I/O bridge. Each cycle it can accept one 64-bit bus address from a downstream device, along with the number of the port the device hangs off. It returns the matching system address, a barrier attribute, a message-signalled-interrupt attribute and the window that decoded the address. When the address cannot be translated, it returns a fault instead.

The bus address space is divided into five windows:

- **64-bit direct.** The system address is carried inside the bus address.
- **32-bit direct.** The upper system bits come from one base register per port.
- **32-bit paged.** Uses 256 KB pages from a shared entry table.
- **40-bit paged.** Uses 64 MB pages from a dedicated entry table.
- **40-bit super-page.** Uses 16 GB pages from a 32-entry slice of the shared table, with the slice chosen by the port.

A configuration write port loads the two direct-map base registers and the entries of both tables. Software decides how entries are allocated, and the block only performs the lookup. The result appears one cycle after the request.

Top module: `dma_xlate`

## Requirements
- R1: After synchronous reset, `rsp_valid` is low and both direct-map base registers read as zero, so a 32-bit direct lookup returns just the low 30 address bits.
- R2: A response is presented exactly one cycle after each accepted request (`req_valid` high), and `rsp_valid` is low in every other cycle; back-to-back requests give back-to-back responses.
- R3: Window decode and `rsp_window` codes:
  - 1: bit 63 set.
  - 2: 0x8000_0000..0xFFFF_FFFF.
  - 3: 0x0..0x7FFF_FFFF.
  - 4: 0x40_0000_0000..0x7F_FFFF_FFFF.
  - 5: 0x80_0000_0000..0xFF_FFFF_FFFF.
  - 0: anything else.
- R4: In window 1, the system address is bus bits 53:0 zero-extended, the barrier is bus bit 62, and MSI is bus bit 61.
- R5: In window 1, any nonzero bit among bus bits 60:54 raises a fault.
- R6: In window 2, the system address is the selected port's base register OR bus bits 29:0. Barrier is bus bit 30, and MSI is always 0. A write to a base register keeps only data bits 53:30.
- R7: In window 3, the shared-table index is bus bits 29:18, the page offset is bits 17:0, and the barrier is bus bit 30.
- R8: In window 4, the 40-bit-table index is bus bits 37:26, the page offset is bits 25:0, and the barrier is always 0.
- R9: In window 5, the shared-table index is port*32 + bus bits 38:34, the page offset is bits 33:0, and the barrier is always 0.
- R10: A table entry is valid when bit 63 is set, and bit 62 gives MSI. Bits 53:0 hold the page base, and any base bits below the page size are ignored. The system address is base plus offset.
- R11: A paged lookup faults when the entry is invalid or the index is at or beyond the table depth.
- R12: An address outside every window faults, with window code 0.
- R13: A faulting response carries system address 0, barrier 0 and MSI 0.
- R14: Configuration write targets (`cfg_target`):
  - 0: port 0 base register.
  - 1: port 1 base register.
  - 2: shared-table entry `cfg_index`.
  - 3: 40-bit-table entry `cfg_index`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_addr | input | 64 | Bus address to translate |
| req_port | input | 1 | Downstream port of the requester (0 or 1) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_target | input | 2 | Write target select |
| cfg_index | input | CFG_AW | Entry index for table writes |
| cfg_data | input | 64 | Write data |
| rsp_valid | output | 1 | Response strobe |
| rsp_addr | output | 64 | Translated system address |
| rsp_barrier | output | 1 | Barrier attribute |
| rsp_msi | output | 1 | MSI attribute |
| rsp_fault | output | 1 | Translation fault |
| rsp_window | output | 3 | Decoded window code |

## Verification
The hardest situation to reach is the super-page window. There, the same bus address must resolve to two different shared-table entries depending on the requesting port, and those entries share storage with the 32-bit paged window. The stimulus loads shared entries 3 and 35 with different bases and MSI settings, then presents the identical address from each port. The 32-bit paged entries used in other vectors are kept in the upper part of the same table. Invalid entries, indices beyond a table's shrunken depth, reserved bits in the direct window, and an entry rewritten from valid to invalid are each placed so that a wrong index or a missed validity check shows up as a different address or a missing fault.

// File: rtl/dxl_pkg.sv
package dxl_pkg;
  localparam int SYS_W   = 54;  // system address width
  localparam int DIR_LOW = 30;  // low bits taken from the bus in 32-bit direct
  localparam int PG_M32  = 18;  // 256 KB page
  localparam int PG_M40  = 26;  // 64 MB page
  localparam int PG_SUP  = 34;  // 16 GB page
  localparam int IDX_W   = 12;  // widest raw table index

  typedef enum logic [2:0] {
    WIN_NONE = 3'd0,
    WIN_D64  = 3'd1,
    WIN_D32  = 3'd2,
    WIN_M32  = 3'd3,
    WIN_M40  = 3'd4,
    WIN_SUP  = 3'd5
  } win_e;

  typedef struct packed {
    win_e             win;
    logic [IDX_W-1:0] idx;
    logic [PG_SUP-1:0] off;
    logic             barrier;
    logic             msi;
    logic             fault;
    logic [SYS_W-1:0] daddr;
  } dec_t;
endpackage

// File: rtl/dxl_decode.sv
module dxl_decode
  import dxl_pkg::*;
(
  input  logic [63:0]      addr,
  input  logic             port,
  input  logic [SYS_W-1:0] dir_base,
  output dec_t             dec
);
  always_comb begin
    dec       = '0;
    dec.win   = WIN_NONE;
    dec.fault = 1'b1;
    if (addr[63]) begin
      dec.win     = WIN_D64;
      dec.daddr   = addr[SYS_W-1:0];
      dec.barrier = addr[62];
      dec.msi     = addr[61];
      dec.fault   = |addr[60:SYS_W];
    end else if (|addr[62:40]) begin
      dec.win = WIN_NONE;
    end else if (addr[39]) begin
      dec.win   = WIN_SUP;
      dec.idx   = IDX_W'({port, addr[38:PG_SUP]});
      dec.off   = addr[PG_SUP-1:0];
      dec.fault = 1'b0;
    end else if (addr[38]) begin
      dec.win   = WIN_M40;
      dec.idx   = addr[PG_M40+IDX_W-1:PG_M40];
      dec.off   = PG_SUP'(addr[PG_M40-1:0]);
      dec.fault = 1'b0;
    end else if (|addr[37:32]) begin
      dec.win = WIN_NONE;
    end else if (addr[31]) begin
      dec.win     = WIN_D32;
      dec.daddr   = dir_base | SYS_W'(addr[DIR_LOW-1:0]);
      dec.barrier = addr[30];
      dec.fault   = 1'b0;
    end else begin
      dec.win     = WIN_M32;
      dec.idx     = addr[PG_M32+IDX_W-1:PG_M32];
      dec.off     = PG_SUP'(addr[PG_M32-1:0]);
      dec.barrier = addr[30];
      dec.fault   = 1'b0;
    end
  end
endmodule

// File: rtl/dxl_table.sv
module dxl_table #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 64,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/dxl_compose.sv
module dxl_compose
  import dxl_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        vld,
  input  dec_t        dec,
  input  logic [63:0] sh_ent,
  input  logic [63:0] m40_ent,
  output logic        rsp_valid,
  output logic [63:0] rsp_addr,
  output logic        rsp_barrier,
  output logic        rsp_msi,
  output logic        rsp_fault,
  output logic [2:0]  rsp_window
);
  logic [63:0]      ent;
  logic             paged;
  logic [SYS_W-1:0] pmask;
  logic [SYS_W-1:0] sys;
  logic             msi_raw;
  logic             flt;
  logic             unused_ent;

  assign paged      = (dec.win == WIN_M32) || (dec.win == WIN_M40) || (dec.win == WIN_SUP);
  assign ent        = (dec.win == WIN_M40) ? m40_ent : sh_ent;
  assign unused_ent = ^ent[61:SYS_W];

  always_comb begin
    case (dec.win)
      WIN_M32: pmask = SYS_W'((64'd1 << PG_M32) - 64'd1);
      WIN_M40: pmask = SYS_W'((64'd1 << PG_M40) - 64'd1);
      default: pmask = SYS_W'((64'd1 << PG_SUP) - 64'd1);
    endcase
    if (paged) begin
      sys     = (ent[SYS_W-1:0] & ~pmask) | SYS_W'(dec.off);
      msi_raw = ent[62];
    end else begin
      sys     = dec.daddr;
      msi_raw = (dec.win == WIN_D64) ? dec.msi : 1'b0;
    end
    flt = dec.fault || (paged && !ent[63]);
  end

  assign rsp_valid   = vld;
  assign rsp_fault   = vld && flt;
  assign rsp_addr    = (vld && !flt) ? 64'(sys) : 64'd0;
  assign rsp_barrier = vld && !flt && dec.barrier;
  assign rsp_msi     = vld && !flt && msi_raw;
  assign rsp_window  = vld ? dec.win : WIN_NONE;

  // R13
  fault_clean_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> (rsp_addr == 64'd0) && !rsp_barrier && !rsp_msi);
  // R12
  nowin_fault_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_window == 3'd0) |-> rsp_fault);
  // R8
  m40_nobar_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && (rsp_window == 3'd4 || rsp_window == 3'd5)) |-> !rsp_barrier);
  // R6
  d32_nomsi_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_window == 3'd2) |-> !rsp_msi);
  // R4
  d64_width_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_window == 3'd1) |-> (rsp_addr[63:SYS_W] == '0));
endmodule

// File: rtl/dma_xlate.sv
module dma_xlate
  import dxl_pkg::*;
#(
  parameter int SH_DEPTH  = 128,
  parameter int M40_DEPTH = 32,
  localparam int SH_AW    = $clog2(SH_DEPTH),
  localparam int M40_AW   = $clog2(M40_DEPTH),
  localparam int CFG_AW   = (SH_AW > M40_AW) ? SH_AW : M40_AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [63:0]       req_addr,
  input  logic              req_port,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_target,
  input  logic [CFG_AW-1:0] cfg_index,
  input  logic [63:0]       cfg_data,
  output logic              rsp_valid,
  output logic [63:0]       rsp_addr,
  output logic              rsp_barrier,
  output logic              rsp_msi,
  output logic              rsp_fault,
  output logic [2:0]        rsp_window
);
  logic [SYS_W-1:0] dir_q [2];
  dec_t             dec_c, dec_r, dec_q;
  logic             v_q;
  logic             sh_we, m40_we, sh_re, m40_re, idx_ok;
  logic [63:0]      sh_rd, m40_rd;

  // direct-map base registers, one per port
  for (genvar p = 0; p < 2; p++) begin : g_dir
    always_ff @(posedge clk) begin
      if (rst) dir_q[p] <= '0;
      else if (cfg_we && cfg_target == 2'(p))
        dir_q[p] <= {cfg_data[SYS_W-1:DIR_LOW], {DIR_LOW{1'b0}}};
    end
  end

  dxl_decode u_dec (
    .addr     (req_addr),
    .port     (req_port),
    .dir_base (dir_q[req_port]),
    .dec      (dec_c)
  );

  assign idx_ok = (dec_c.win == WIN_M40) ? (int'(dec_c.idx) < M40_DEPTH)
                                         : (int'(dec_c.idx) < SH_DEPTH);
  always_comb begin
    dec_r = dec_c;
    if ((dec_c.win == WIN_M32 || dec_c.win == WIN_M40 || dec_c.win == WIN_SUP) && !idx_ok)
      dec_r.fault = 1'b1;
  end

  assign sh_we  = cfg_we && cfg_target == 2'd2 && int'(cfg_index) < SH_DEPTH;
  assign m40_we = cfg_we && cfg_target == 2'd3 && int'(cfg_index) < M40_DEPTH;
  assign sh_re  = req_valid && (dec_c.win == WIN_M32 || dec_c.win == WIN_SUP);
  assign m40_re = req_valid && dec_c.win == WIN_M40;

  dxl_table #(.DEPTH(SH_DEPTH), .WIDTH(64)) u_sh (
    .clk   (clk),
    .we    (sh_we),
    .waddr (cfg_index[SH_AW-1:0]),
    .wdata (cfg_data),
    .re    (sh_re),
    .raddr (dec_c.idx[SH_AW-1:0]),
    .rdata (sh_rd)
  );

  dxl_table #(.DEPTH(M40_DEPTH), .WIDTH(64)) u_m40 (
    .clk   (clk),
    .we    (m40_we),
    .waddr (cfg_index[M40_AW-1:0]),
    .wdata (cfg_data),
    .re    (m40_re),
    .raddr (dec_c.idx[M40_AW-1:0]),
    .rdata (m40_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q   <= 1'b0;
      dec_q <= '0;
    end else begin
      v_q <= req_valid;
      if (req_valid) dec_q <= dec_r;
    end
  end

  dxl_compose u_cmp (
    .clk         (clk),
    .rst         (rst),
    .vld         (v_q),
    .dec         (dec_q),
    .sh_ent      (sh_rd),
    .m40_ent     (m40_rd),
    .rsp_valid   (rsp_valid),
    .rsp_addr    (rsp_addr),
    .rsp_barrier (rsp_barrier),
    .rsp_msi     (rsp_msi),
    .rsp_fault   (rsp_fault),
    .rsp_window  (rsp_window)
  );

  // R2
  lat_hit_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  // R2
  lat_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !rsp_valid);
endmodule

// File: tb/dma_xlate_bench.sv
`timescale 1ns/1ps
module dma_xlate_bench;
  localparam int SH_D = 128;
  localparam int M4_D = 32;
  localparam int CAW  = 7;

  logic           clk = 1'b0;
  logic           rst;
  logic           req_valid;
  logic [63:0]    req_addr;
  logic           req_port;
  logic           cfg_we;
  logic [1:0]     cfg_target;
  logic [CAW-1:0] cfg_index;
  logic [63:0]    cfg_data;
  logic           rsp_valid, rsp_barrier, rsp_msi, rsp_fault;
  logic [63:0]    rsp_addr;
  logic [2:0]     rsp_window;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  dma_xlate #(.SH_DEPTH(SH_D), .M40_DEPTH(M4_D)) u_dma_xlate (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_port(req_port), .cfg_we(cfg_we), .cfg_target(cfg_target),
    .cfg_index(cfg_index), .cfg_data(cfg_data), .rsp_valid(rsp_valid),
    .rsp_addr(rsp_addr), .rsp_barrier(rsp_barrier), .rsp_msi(rsp_msi),
    .rsp_fault(rsp_fault), .rsp_window(rsp_window)
  );

  typedef struct packed {
    logic [63:0] addr;
    logic        port;
    logic [63:0] ea;
    logic        eb;
    logic        em;
    logic        ef;
    logic [2:0]  ew;
    int          rq;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{64'h0000_0000_0119_2345, 1'b0, 64'h0000_0001_2341_2345, 1'b0, 1'b1, 1'b0, 3'd3, 7},  // R7
    '{64'h0000_0000_4119_2345, 1'b0, 64'h0000_0001_2341_2345, 1'b1, 1'b1, 1'b0, 3'd3, 7},  // R7
    '{64'h0000_0000_011C_0000, 1'b0, 64'h0000_0000_0ABC_0000, 1'b0, 1'b0, 1'b0, 3'd3, 10}, // R10
    '{64'h0000_0000_0120_0000, 1'b0, 64'h0,                   1'b0, 1'b0, 1'b1, 3'd3, 11}, // R11
    '{64'h0000_0000_0320_0000, 1'b0, 64'h0,                   1'b0, 1'b0, 1'b1, 3'd3, 11}, // R11
    '{64'h0000_0040_1523_4567, 1'b0, 64'h0000_0000_4523_4567, 1'b0, 1'b0, 1'b0, 3'd4, 8},  // R8
    '{64'h0000_0040_4000_0010, 1'b1, 64'h0000_0000_0800_0010, 1'b0, 1'b1, 1'b0, 3'd4, 8},  // R8
    '{64'h0000_0040_A000_0000, 1'b0, 64'h0,                   1'b0, 1'b0, 1'b1, 3'd4, 11}, // R11
    '{64'h0000_008D_2345_6789, 1'b0, 64'h0000_0009_2345_6789, 1'b0, 1'b0, 1'b0, 3'd5, 9},  // R9
    '{64'h0000_008D_2345_6789, 1'b1, 64'h0000_0011_2345_6789, 1'b0, 1'b1, 1'b0, 3'd5, 9},  // R9
    '{64'hE000_1234_5678_9ABC, 1'b0, 64'h0000_1234_5678_9ABC, 1'b1, 1'b1, 1'b0, 3'd1, 4},  // R4
    '{64'h8040_0000_0000_0000, 1'b1, 64'h0,                   1'b0, 1'b0, 1'b1, 3'd1, 5},  // R5
    '{64'h8000_0000_0000_1000, 1'b0, 64'h0000_0000_0000_1000, 1'b0, 1'b0, 1'b0, 3'd1, 4},  // R4
    '{64'h0000_0000_8123_4567, 1'b0, 64'h0000_0012_0123_4567, 1'b0, 1'b0, 1'b0, 3'd2, 6},  // R6
    '{64'h0000_0000_C000_0042, 1'b1, 64'h0000_0000_C000_0042, 1'b1, 1'b0, 1'b0, 3'd2, 6},  // R6
    '{64'h0000_0001_0000_0000, 1'b0, 64'h0,                   1'b0, 1'b0, 1'b1, 3'd0, 12}, // R12
    '{64'h0000_0100_0000_0000, 1'b0, 64'h0,                   1'b0, 1'b0, 1'b1, 3'd0, 12}, // R12
    '{64'h4000_0000_0000_0000, 1'b1, 64'h0,                   1'b0, 1'b0, 1'b1, 3'd0, 3}   // R3
  };

  task automatic cfg_wr(input logic [1:0] tgt, input int idx, input logic [63:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_target = tgt; cfg_index = CAW'(idx); cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic check_rsp(input int rq, input logic [63:0] ea, input logic eb,
                           input logic em, input logic ef, input logic [2:0] ew);
    checks++;
    if (!rsp_valid || rsp_addr !== ea || rsp_barrier !== eb || rsp_msi !== em ||
        rsp_fault !== ef || rsp_window !== ew) begin
      errors++;
      $display("FAIL R%0d: got v=%b a=%h b=%b m=%b f=%b w=%0d, expected v=1 a=%h b=%b m=%b f=%b w=%0d",
               rq, rsp_valid, rsp_addr, rsp_barrier, rsp_msi, rsp_fault, rsp_window,
               ea, eb, em, ef, ew);
    end
  endtask

  task automatic drive(input logic [63:0] a, input logic p);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_port = p;
  endtask

  task automatic xlate(input logic [63:0] a, input logic p, input int rq,
                       input logic [63:0] ea, input logic eb, input logic em,
                       input logic ef, input logic [2:0] ew);
    drive(a, p);
    @(negedge clk);
    req_valid = 1'b0;
    check_rsp(rq, ea, eb, em, ef, ew);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_addr = '0; req_port = 1'b0;
    cfg_we = 1'b0; cfg_target = '0; cfg_index = '0; cfg_data = '0;
    repeat (3) @(negedge clk);
    // R1: no response while and right after reset
    checks++;
    if (rsp_valid !== 1'b0) begin
      errors++; $display("FAIL R1: rsp_valid=%b expected 0", rsp_valid);
    end
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0) begin
      errors++; $display("FAIL R1: rsp_valid=%b expected 0 after reset", rsp_valid);
    end
    // R1: base registers cleared
    xlate(64'h0000_0000_8000_0005, 1'b0, 1, 64'h5, 1'b0, 1'b0, 1'b0, 3'd2);

    // R14: clear both tables, then load entries
    for (int i = 0; i < SH_D; i++) cfg_wr(2'd2, i, 64'h0);
    for (int i = 0; i < M4_D; i++) cfg_wr(2'd3, i, 64'h0);
    cfg_wr(2'd0, 0, 64'h0000_0012_3456_789A);
    cfg_wr(2'd1, 0, 64'h0000_0000_C000_0000);
    cfg_wr(2'd2, 70, 64'hC000_0001_2340_0000);
    cfg_wr(2'd2, 71, 64'h8000_0000_0ABC_DEF0);
    cfg_wr(2'd3, 5,  64'h8000_0000_4400_0000);
    cfg_wr(2'd3, 16, 64'hC000_0000_0800_0000);
    cfg_wr(2'd2, 3,  64'h8000_0008_0000_0000);
    cfg_wr(2'd2, 35, 64'hC000_0010_0000_0000);

    for (int k = 0; k < NV; k++)
      xlate(VECS[k].addr, VECS[k].port, VECS[k].rq, VECS[k].ea,
            VECS[k].eb, VECS[k].em, VECS[k].ef, VECS[k].ew);

    // R2: idle cycle gives no response
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0) begin
      errors++; $display("FAIL R2: rsp_valid=%b expected 0 when idle", rsp_valid);
    end

    // R2: back-to-back requests
    drive(64'h8000_0000_0000_0AAA, 1'b0);
    drive(64'h0000_0040_1523_4567, 1'b0);
    check_rsp(2, 64'hAAA, 1'b0, 1'b0, 1'b0, 3'd1);
    @(negedge clk);
    req_valid = 1'b0;
    check_rsp(2, 64'h0000_0000_4523_4567, 1'b0, 1'b0, 1'b0, 3'd4);

    // R13 / R10: entry rewritten invalid with MSI bit set faults cleanly
    cfg_wr(2'd2, 70, 64'h4000_0001_2340_0000);
    xlate(64'h0000_0000_0119_2345, 1'b0, 13, 64'h0, 1'b0, 1'b0, 1'b1, 3'd3);

    // R1: reset mid-run clears the base registers
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    xlate(64'h0000_0000_C000_0042, 1'b1, 1, 64'h42, 1'b1, 1'b0, 1'b0, 3'd2);

    done = 1'b1;
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete");
      summary();
    end
  end
endmodule